// File: doc/BRIEF.md
# Timer Output Compare Unit

A 16-bit up-counter with one output compare channel, driven from an 8-bit register bus. The counter and the compare register each occupy a high-byte and a low-byte address. One shared temporary byte lets software move a full 16-bit value in a single step. Counting is paced by an external tick input and gated by a clock-select field. On every running tick the counter is compared against the compare register. An equal value raises a compare flag, which also serves as the interrupt request. A control bit can make the counter return to zero on a match.

A bus write to the counter arms a one-shot blocking latch. The latch suppresses the whole compare evaluation on the next running tick. Software can therefore load the counter with the compare value, even while the timer is stopped, and no spurious event follows when counting resumes. The flag is cleared by writing a one to it or by an acknowledge pulse. A new match in the same cycle takes priority over the clear.

Top module: `tmr_ocu`

## Requirements
- R1: After reset the counter, the compare register, the control register and the compare flag are all zero.
- R2: The control register at address 4 holds clock select in bits 2:0 and clear-on-match in bit 3. Bits 7:4 always read as zero.
- R3: A write to a high-byte address (1 for the counter, 3 for compare) only loads the temporary byte. A write to the matching low-byte address (0 or 2) loads {temporary, data} into the 16-bit register in one cycle.
- R4: A read of address 0 returns the counter low byte and copies the counter high byte into the temporary byte. A read of address 1 returns the temporary byte. Compare bytes at addresses 2 and 3 read back directly.
- R5: With clock select zero, ticks leave the counter unchanged. With any nonzero value, each tick adds one, wrapping from 0xFFFF to 0x0000.
- R6: On a running tick where the counter equals the compare value, the flag (bit 0 of address 5, cmp_flag_o and irq_o) becomes 1.
- R7: With clear-on-match set, a matching running tick loads zero into the counter instead of incrementing it.
- R8: A counter write suppresses the match, the flag set and the clear on the first running tick that follows. This holds even if the timer was stopped when the write occurred. That tick still increments the counter.
- R9: Writing a 1 to bit 0 of address 5, or pulsing irq_ack_i, clears the flag. Writing 0 has no effect. A set in the same cycle wins.
- R10: A counter write in the same cycle as a tick takes the written value, and the tick is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Timer clock-enable pulse |
| bus_addr_i | input | 3 | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational while bus_rd_i is high, else zero |
| irq_ack_i | input | 1 | Interrupt acknowledge, clears the flag |
| cmp_flag_o | output | 1 | Compare flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the block that persists across a stopped period. The counter is loaded with the compare value while clock select is zero. Several ticks are then applied that must change nothing. Counting is then enabled, and the first running tick must give neither flag nor clear. A second hard case is a set and a clear landing together. The bench walks the counter to one below the compare value, then drives the matching tick and irq_ack_i in the same cycle.

// File: rtl/tmr_ocu_pkg.sv
package tmr_ocu_pkg;
   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      A_CNT_LO = 3'd0,
      A_CNT_HI = 3'd1,
      A_OCR_LO = 3'd2,
      A_OCR_HI = 3'd3,
      A_CTRL   = 3'd4,
      A_FLAG   = 3'd5
   } reg_addr_e;
endpackage

// File: rtl/tmr_ocu_bus.sv
module tmr_ocu_bus
   import tmr_ocu_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 16,
   parameter int CS_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic              flag_i,
   output logic              cnt_wr_o,
   output logic [CNT_W-1:0]  cnt_wdata_o,
   output logic [CNT_W-1:0]  ocr_o,
   output logic [CS_W-1:0]   cs_o,
   output logic              ctc_o,
   output logic              flag_clr_o
);
   localparam int PAD_W = DATA_W - CS_W - 1;

   logic [DATA_W-1:0] temp_q;
   logic [CNT_W-1:0]  ocr_q;
   logic [CS_W-1:0]   cs_q;
   logic              ctc_q;

   logic wr_cnt_lo, wr_cnt_hi, wr_ocr_lo, wr_ocr_hi, wr_ctrl, rd_cnt_lo;
   assign wr_cnt_lo = wr_i && (addr_i == A_CNT_LO);
   assign wr_cnt_hi = wr_i && (addr_i == A_CNT_HI);
   assign wr_ocr_lo = wr_i && (addr_i == A_OCR_LO);
   assign wr_ocr_hi = wr_i && (addr_i == A_OCR_HI);
   assign wr_ctrl   = wr_i && (addr_i == A_CTRL);
   assign rd_cnt_lo = rd_i && (addr_i == A_CNT_LO);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         temp_q <= '0;
         ocr_q  <= '0;
         cs_q   <= '0;
         ctc_q  <= 1'b0;
      end else begin
         if (wr_cnt_hi || wr_ocr_hi)
            temp_q <= wdata_i;
         else if (rd_cnt_lo && !wr_i)
            temp_q <= cnt_i[CNT_W-1 -: DATA_W];
         if (wr_ocr_lo)
            ocr_q <= {temp_q, wdata_i};
         if (wr_ctrl) begin
            cs_q  <= wdata_i[CS_W-1:0];
            ctc_q <= wdata_i[CS_W];
         end
      end
   end

   assign cnt_wr_o    = wr_cnt_lo;
   assign cnt_wdata_o = {temp_q, wdata_i};
   assign ocr_o       = ocr_q;
   assign cs_o        = cs_q;
   assign ctc_o       = ctc_q;
   assign flag_clr_o  = wr_i && (addr_i == A_FLAG) && wdata_i[0];

   always_comb begin
      rdata_o = '0;
      if (rd_i) begin
         case (addr_i)
            A_CNT_LO: rdata_o = cnt_i[DATA_W-1:0];
            A_CNT_HI: rdata_o = temp_q;
            A_OCR_LO: rdata_o = ocr_q[DATA_W-1:0];
            A_OCR_HI: rdata_o = ocr_q[CNT_W-1 -: DATA_W];
            A_CTRL:   rdata_o = {{PAD_W{1'b0}}, ctc_q, cs_q};
            A_FLAG:   rdata_o = {{(DATA_W-1){1'b0}}, flag_i};
            default:  rdata_o = '0;
         endcase
      end
   end

   // R3: a low-byte write commits the held high byte together with the data
   a_r3_commit: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ocr_lo |=> ocr_q == {$past(temp_q), $past(wdata_i)});
   // R4: reading the counter low byte snapshots its high byte
   a_r4_latch: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_cnt_lo && !wr_i) |=> temp_q == $past(cnt_i[CNT_W-1 -: DATA_W]));
   // R2: reserved control bits read zero
   a_r2_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && addr_i == A_CTRL) |-> rdata_o[DATA_W-1:CS_W+1] == '0);
endmodule

// File: rtl/tmr_ocu_core.sv
module tmr_ocu_core #(
   parameter int CNT_W  = 16,
   parameter int CS_W   = 3,
   parameter bit ACK_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic [CS_W-1:0]  cs_i,
   input  logic             ctc_i,
   input  logic [CNT_W-1:0] ocr_i,
   input  logic             cnt_wr_i,
   input  logic [CNT_W-1:0] cnt_wdata_i,
   input  logic             flag_clr_i,
   input  logic             irq_ack_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             flag_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             blk_q, flag_q, ack_eff;
   logic             run_tick, eval, hit;

   generate
      if (ACK_EN) begin : g_ack
         assign ack_eff = irq_ack_i;
      end else begin : g_no_ack
         assign ack_eff = 1'b0;
      end
   endgenerate

   assign run_tick = tick_i && (cs_i != '0);
   assign eval     = run_tick && !cnt_wr_i;
   assign hit      = eval && !blk_q && (cnt_q == ocr_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         blk_q  <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         if (cnt_wr_i)
            cnt_q <= cnt_wdata_i;
         else if (run_tick)
            cnt_q <= (hit && ctc_i) ? '0 : cnt_q + CNT_W'(1);

         if (cnt_wr_i)
            blk_q <= 1'b1;
         else if (run_tick)
            blk_q <= 1'b0;

         if (hit)
            flag_q <= 1'b1;
         else if (flag_clr_i || ack_eff)
            flag_q <= 1'b0;
      end
   end

   assign cnt_o  = cnt_q;
   assign flag_o = flag_q;

   // R5: no running tick and no write leaves the counter alone
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_tick && !cnt_wr_i) |=> $stable(cnt_q));
   // R5: a running tick without clear-on-match counts up by one
   a_r5_inc: assert property (@(posedge clk) disable iff (!rst_n)
      (eval && !ctc_i) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
   // R8: a pending block keeps a clear flag clear and prevents the clear
   a_r8_block: assert property (@(posedge clk) disable iff (!rst_n)
      (eval && blk_q && !flag_q) |=> !flag_q && cnt_q == $past(cnt_q) + CNT_W'(1));
   // R9: a match wins over any clear in the same cycle
   a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (eval && !blk_q && cnt_q == ocr_i) |=> flag_q);
   // R10: a counter write always lands its value
   a_r10_write: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr_i |=> cnt_q == $past(cnt_wdata_i) && blk_q);
endmodule

// File: rtl/tmr_ocu.sv
module tmr_ocu
   import tmr_ocu_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 16,
   parameter int CS_W   = 3,
   parameter bit ACK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic              bus_wr_i,
   input  logic              bus_rd_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   input  logic              irq_ack_i,
   output logic              cmp_flag_o,
   output logic              irq_o
);
   generate
      if (CNT_W != 2 * DATA_W) begin : g_bad_width
         $error("CNT_W must be twice DATA_W");
      end
      if (CS_W < 1 || CS_W > DATA_W - 2) begin : g_bad_cs
         $error("CS_W must leave room for the clear bit and one reserved bit");
      end
   endgenerate

   logic [CNT_W-1:0] cnt, cnt_wdata, ocr;
   logic [CS_W-1:0]  cs;
   logic             ctc, cnt_wr, flag_clr, flag;

   tmr_ocu_bus #(.DATA_W(DATA_W), .CNT_W(CNT_W), .CS_W(CS_W)) u_bus (
      .clk(clk), .rst_n(rst_n), .addr_i(bus_addr_i), .wr_i(bus_wr_i),
      .rd_i(bus_rd_i), .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o),
      .cnt_i(cnt), .flag_i(flag), .cnt_wr_o(cnt_wr), .cnt_wdata_o(cnt_wdata),
      .ocr_o(ocr), .cs_o(cs), .ctc_o(ctc), .flag_clr_o(flag_clr)
   );

   tmr_ocu_core #(.CNT_W(CNT_W), .CS_W(CS_W), .ACK_EN(ACK_EN)) u_core (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cs_i(cs), .ctc_i(ctc),
      .ocr_i(ocr), .cnt_wr_i(cnt_wr), .cnt_wdata_i(cnt_wdata),
      .flag_clr_i(flag_clr), .irq_ack_i(irq_ack_i), .cnt_o(cnt), .flag_o(flag)
   );

   assign cmp_flag_o = flag;
   assign irq_o      = flag;

   // R6: the flag only rises on a running tick
   a_r6_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(tick_i) && $past(cs) != '0);
   // R9: a flag write of zero never clears the flag
   a_r9_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && bus_wr_i && bus_addr_i == A_FLAG && !bus_wdata_i[0] && !irq_ack_i) |=> flag);
endmodule

// File: tb/tmr_ocu_bench.sv
module tmr_ocu_bench;
   localparam int PERIOD = 10;
   localparam logic [2:0] CLO = 3'd0, CHI = 3'd1, OLO = 3'd2, OHI = 3'd3,
                          CTL = 3'd4, FLG = 3'd5;

   logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
   logic [2:0] addr = '0;
   logic       wr = 1'b0, rd = 1'b0, ack = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       flag, irq;
   int n_chk = 0, n_bad = 0;

   always #(PERIOD/2) clk = ~clk;

   tmr_ocu u_tmr_ocu (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .bus_addr_i(addr),
      .bus_wr_i(wr), .bus_rd_i(rd), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
      .irq_ack_i(ack), .cmp_flag_o(flag), .irq_o(irq)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic bwr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; wr = 1'b1;
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic brd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
      @(negedge clk); rd = 1'b0;
   endtask

   task automatic set16(input logic [2:0] lo, input logic [15:0] v);
      bwr(lo + 3'd1, v[15:8]); bwr(lo, v[7:0]);
   endtask

   task automatic get_cnt(output logic [15:0] v);
      logic [7:0] l, h;
      brd(CLO, l); brd(CHI, h); v = {h, l};
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
      end
   endtask

   task automatic clr_flag();
      bwr(FLG, 8'h01);
   endtask

   task automatic t_reset();
      logic [7:0] d; logic [15:0] c;
      get_cnt(c); chk(c == 16'h0, "R1 counter", c, 0);
      brd(OLO, d); chk(d == 8'h0, "R1 compare low", d, 0);
      brd(CTL, d); chk(d == 8'h0, "R1 control", d, 0);
      chk(flag == 1'b0 && irq == 1'b0, "R1 flag", flag, 0);
   endtask

   task automatic t_ctrl();
      logic [7:0] d;
      bwr(CTL, 8'hFF); brd(CTL, d); chk(d == 8'h0F, "R2 reserved bits", d, 8'h0F);
      bwr(CTL, 8'h00);
   endtask

   task automatic t_wide_write();
      logic [7:0] d; logic [15:0] c;
      set16(CLO, 16'h1234); get_cnt(c); chk(c == 16'h1234, "R3 counter write", c, 16'h1234);
      bwr(CHI, 8'h55); get_cnt(c); chk(c == 16'h1234, "R3 high only", c, 16'h1234);
      set16(OLO, 16'hA5C3); brd(OHI, d); chk(d == 8'hA5, "R3 compare high", d, 8'hA5);
      brd(OLO, d); chk(d == 8'hC3, "R3 compare low", d, 8'hC3);
   endtask

   task automatic t_read_latch();
      logic [7:0] d; logic [15:0] c;
      set16(OLO, 16'h1234); bwr(CTL, 8'h01);
      set16(CLO, 16'h00FF);
      brd(CLO, d); chk(d == 8'hFF, "R4 low read", d, 8'hFF);
      ticks(1);
      brd(CHI, d); chk(d == 8'h00, "R4 latched high", d, 0);
      get_cnt(c); chk(c == 16'h0100, "R4 fresh read", c, 16'h0100);
   endtask

   task automatic t_count();
      logic [15:0] c;
      bwr(CTL, 8'h00); set16(CLO, 16'h0200); ticks(3);
      get_cnt(c); chk(c == 16'h0200, "R5 stopped", c, 16'h0200);
      bwr(CTL, 8'h05); ticks(4);
      get_cnt(c); chk(c == 16'h0204, "R5 counting", c, 16'h0204);
      set16(CLO, 16'hFFFE); ticks(2);
      get_cnt(c); chk(c == 16'h0000, "R5 wrap", c, 0);
      chk(flag == 1'b0, "R5 no match", flag, 0);
   endtask

   task automatic t_match();
      logic [7:0] d; logic [15:0] c;
      bwr(CTL, 8'h01); set16(OLO, 16'h0010); set16(CLO, 16'h000E);
      ticks(2); chk(flag == 1'b0, "R6 before match", flag, 0);
      ticks(1); chk(flag == 1'b1 && irq == 1'b1, "R6 match flag", flag, 1);
      get_cnt(c); chk(c == 16'h0011, "R6 keeps counting", c, 16'h0011);
      brd(FLG, d); chk(d == 8'h01, "R6 flag read", d, 1);
      bwr(FLG, 8'h00); chk(flag == 1'b1, "R9 zero write", flag, 1);
      clr_flag(); chk(flag == 1'b0, "R9 write one", flag, 0);
   endtask

   task automatic t_ctc();
      logic [15:0] c;
      bwr(CTL, 8'h09); set16(OLO, 16'h0005); set16(CLO, 16'h0003);
      ticks(2); get_cnt(c); chk(c == 16'h0005, "R7 reach", c, 5);
      ticks(1); get_cnt(c); chk(c == 16'h0000, "R7 cleared", c, 0);
      chk(flag == 1'b1, "R7 flag", flag, 1);
      @(negedge clk); ack = 1'b1; @(negedge clk); ack = 1'b0;
      chk(flag == 1'b0, "R9 ack clear", flag, 0);
   endtask

   task automatic t_block();
      logic [15:0] c;
      set16(OLO, 16'h0050);
      bwr(CTL, 8'h09); set16(CLO, 16'h0050); ticks(1);
      get_cnt(c); chk(c == 16'h0051, "R8 running no clear", c, 16'h0051);
      chk(flag == 1'b0, "R8 running no flag", flag, 0);
      bwr(CTL, 8'h00); set16(CLO, 16'h0050); ticks(2);
      get_cnt(c); chk(c == 16'h0050, "R8 stopped hold", c, 16'h0050);
      bwr(CTL, 8'h01); ticks(1);
      chk(flag == 1'b0, "R8 block survives stop", flag, 0);
      get_cnt(c); chk(c == 16'h0051, "R8 first tick counts", c, 16'h0051);
   endtask

   task automatic t_set_wins();
      bwr(CTL, 8'h01); set16(OLO, 16'h0040); set16(CLO, 16'h003F); ticks(1);
      @(negedge clk); tick = 1'b1; ack = 1'b1;
      @(negedge clk); tick = 1'b0; ack = 1'b0;
      chk(flag == 1'b1, "R9 set wins", flag, 1);
      clr_flag();
   endtask

   task automatic t_write_tick();
      logic [15:0] c;
      bwr(CTL, 8'h01); bwr(CHI, 8'h07);
      @(negedge clk); addr = CLO; wdata = 8'h70; wr = 1'b1; tick = 1'b1;
      @(negedge clk); wr = 1'b0; tick = 1'b0;
      get_cnt(c); chk(c == 16'h0770, "R10 write wins", c, 16'h0770);
   endtask

   initial begin
      #(PERIOD * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_ctrl();
      t_wide_write();
      t_read_latch();
      t_count();
      t_match();
      t_ctc();
      t_block();
      t_set_wins();
      t_write_tick();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule